// File: doc/BRIEF.md
# Arithmetic Status Flags and Branch Condition Unit

This block performs a 32-bit add, subtract or compare on two operands and derives the six arithmetic status flags from the operation: carry, parity, auxiliary carry, zero, sign and overflow. It can capture them in a packed 32-bit flags register. The difference or sum is available combinationally on the result output.

A 4-bit condition code selects one of sixteen tests. These cover the single-flag tests and the full sets of signed and unsigned ordering tests. The selected test is evaluated against the stored flags, and the answer drives a single true/false output that a conditional branch can consume.

Because the condition looks only at the registered flags, a compare in one cycle drives the branch decision from the next cycle onward.

Top module: `flag_cond_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and after it, until the first flag write, the flags word reads 32'h0000_0002.
- R2: Operation select op is 2'b00 for add, 2'b01 for subtract (op_a minus op_b) and 2'b10 for compare. The value 2'b11 acts as compare. For add and subtract, result is the 32-bit sum or difference.
- R3: The carry flag (bit 0) is the carry out of bit 31 on add. On subtract and compare it is the borrow, which is 1 exactly when op_a < op_b as unsigned numbers.
- R4: The zero flag (bit 6) is 1 when the 32-bit sum or difference is zero. The sign flag (bit 7) copies its bit 31. The overflow flag (bit 11) is 1 when the true signed result lies outside the signed 32-bit range.
- R5: The parity flag (bit 2) is 1 when bits 7..0 of the sum or difference hold an even number of ones. The auxiliary flag (bit 4) is the carry out of bit 3 on add, or the borrow into bit 4 on subtract.
- R6: Compare sets the flags exactly as subtract of the same operands would, and its result output equals op_a unchanged.
- R7: When flag_we is low, the flags register keeps its value across the clock edge, whatever the operands and op.
- R8: In the flags word, bit 1 always reads 1. All bits other than 0, 1, 2, 4, 6, 7 and 11 always read 0.
- R9: The even condition codes are tests. 0 is overflow set. 2 is carry set (unsigned below). 4 is zero set (equal). 6 is carry or zero set (unsigned below-or-equal). 8 is sign set. 10 is parity set. 12 is sign not equal to overflow (signed less). 14 is zero set or sign not equal to overflow (signed less-or-equal).
- R10: Each odd condition code 2k+1 yields the inverse of code 2k: no overflow, unsigned above-or-equal, not equal, unsigned above, no sign, parity odd, signed greater-or-equal, signed greater.
- R11: cond_true depends only on cond and the registered flags. In a cycle that writes the flags, cond_true still shows the old flags until the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op | input | 2 | Operation select (add, sub, cmp) |
| flag_we | input | 1 | Capture new flags on the next edge |
| cond | input | 4 | Condition code to evaluate |
| result | output | 32 | Sum, difference, or op_a on compare |
| flags | output | 32 | Packed registered flags word |
| cond_true | output | 1 | Selected condition holds on stored flags |

## Verification
A flag write and a condition evaluation can share a cycle. In that case the branch output must still follow the flags of the previous operation.

The bench provokes this collision by sweeping condition codes while new compares with flag_we high are being applied. Each cycle's expected output is computed from a reference flags model that advances only after the item for that cycle has been queued. A design that lets the fresh flags leak through combinationally is therefore judged wrong on the cycle of the write.

// File: rtl/flag_cond_unit.sv
module flag_cond_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   op,
  input  logic         flag_we,
  input  logic [3:0]   cond,
  output logic [W-1:0] result,
  output logic [31:0]  flags,
  output logic         cond_true
);
  localparam logic [31:0] RESET_FLAGS = 32'h0000_0002;
  localparam logic [31:0] LIVE_MASK   = 32'h0000_08D5;

  logic         is_sub;
  logic [W:0]   sum;
  logic [W-1:0] diff;
  logic         cf_n, pf_n, af_n, zf_n, sf_n, of_n;
  logic [31:0]  flags_next;
  logic [31:0]  flags_q;
  logic         base;

  assign is_sub = (op != 2'b00);
  assign sum    = {1'b0, op_a} + {1'b0, (is_sub ? ~op_b : op_b)} + {{W{1'b0}}, is_sub};
  assign diff   = sum[W-1:0];
  assign result = op[1] ? op_a : diff;

  assign cf_n = is_sub ? ~sum[W] : sum[W];
  assign pf_n = ~^diff[7:0];
  assign af_n = op_a[4] ^ op_b[4] ^ diff[4];
  assign zf_n = (diff == '0);
  assign sf_n = diff[W-1];
  assign of_n = is_sub ? ((op_a[W-1] != op_b[W-1]) && (diff[W-1] != op_a[W-1]))
                       : ((op_a[W-1] == op_b[W-1]) && (diff[W-1] != op_a[W-1]));

  assign flags_next = {20'b0, of_n, 3'b0, sf_n, zf_n, 1'b0, af_n, 1'b0, pf_n, 1'b1, cf_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= RESET_FLAGS;
    else if (flag_we) flags_q <= flags_next;
  end

  assign flags = flags_q;

  always_comb begin
    case (cond[3:1])
      3'd0:    base = flags_q[11];
      3'd1:    base = flags_q[0];
      3'd2:    base = flags_q[6];
      3'd3:    base = flags_q[0] | flags_q[6];
      3'd4:    base = flags_q[7];
      3'd5:    base = flags_q[2];
      3'd6:    base = flags_q[7] ^ flags_q[11];
      default: base = flags_q[6] | (flags_q[7] ^ flags_q[11]);
    endcase
  end

  assign cond_true = base ^ cond[0];

  logic [W:0] chk_add;
  assign chk_add = {1'b0, op_a} + {1'b0, op_b};

  a_r8_reserved_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~LIVE_MASK) == RESET_FLAGS);

  a_r7_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags));

  a_r3_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op == 2'b00) |=> flags[0] == $past(chk_add[W]));

  a_r4_zero_on_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op != 2'b00) |=> flags[6] == ($past(op_a) == $past(op_b)));
endmodule

// File: tb/flag_cond_unit_test.sv
`timescale 1ns/1ps
module flag_cond_unit_test;
  typedef struct {
    logic [31:0] res;
    logic [31:0] fl;
    logic        ct;
    string       tag;
  } item_t;

  logic clk = 0, rst_n = 0, flag_we = 0, cond_true;
  logic [31:0] op_a = 0, op_b = 0, result, flags;
  logic [1:0]  op = 0;
  logic [3:0]  cond = 0;
  int checks = 0, fails = 0;
  item_t q[$];
  logic [31:0] mflags = 32'h2;
  bit done = 0;

  always #2.5 clk = ~clk;

  flag_cond_unit uut (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op(op),
    .flag_we(flag_we), .cond(cond), .result(result), .flags(flags), .cond_true(cond_true));

  function automatic void model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] o,
                                output logic [31:0] res, output logic [31:0] fl);
    logic [32:0] s;
    logic [31:0] d;
    longint r;
    logic cf, pf, af, zf, sf, ov;
    bit sub;
    sub = (o != 2'b00);
    s = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    d = s[31:0];
    cf = s[32];
    r = sub ? (longint'($signed(a)) - longint'($signed(b))) : (longint'($signed(a)) + longint'($signed(b)));
    ov = (r > 64'sd2147483647) || (r < -64'sd2147483648);
    af = sub ? (a[3:0] < b[3:0]) : ((a[3:0] + b[3:0]) > 5'd15);
    pf = ($countones(d[7:0]) % 2) == 0;
    zf = (d == 0);
    sf = d[31];
    fl = 32'h2;
    fl[0] = cf; fl[2] = pf; fl[4] = af; fl[6] = zf; fl[7] = sf; fl[11] = ov;
    res = o[1] ? a : d;
  endfunction

  function automatic logic cmodel(input logic [3:0] c, input logic [31:0] f);
    logic cf, zf, sf, ov, pf;
    cf = f[0]; pf = f[2]; zf = f[6]; sf = f[7]; ov = f[11];
    case (c)
      4'd0:  return ov;
      4'd1:  return !ov;
      4'd2:  return cf;
      4'd3:  return !cf;
      4'd4:  return zf;
      4'd5:  return !zf;
      4'd6:  return cf || zf;
      4'd7:  return !cf && !zf;
      4'd8:  return sf;
      4'd9:  return !sf;
      4'd10: return pf;
      4'd11: return !pf;
      4'd12: return sf != ov;
      4'd13: return sf == ov;
      4'd14: return zf || (sf != ov);
      default: return !zf && (sf == ov);
    endcase
  endfunction

  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [1:0] o,
                      input logic we, input logic [3:0] c, input string tag);
    item_t it;
    logic [31:0] res, fl;
    @(posedge clk); #1;
    op_a = a; op_b = b; op = o; flag_we = we; cond = c;
    model(a, b, o, res, fl);
    it.res = res; it.fl = mflags; it.ct = cmodel(c, mflags); it.tag = tag;
    q.push_back(it);
    if (we) mflags = fl;
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (result !== it.res) begin
        fails++; $display("FAIL %s result: actual %h expected %h", it.tag, result, it.res);
      end
      checks++;
      if (flags !== it.fl) begin
        fails++; $display("FAIL %s flags: actual %h expected %h", it.tag, flags, it.fl);
      end
      checks++;
      if (cond_true !== it.ct) begin
        fails++; $display("FAIL %s cond_true (cond %0d): actual %b expected %b", it.tag, cond, cond_true, it.ct);
      end
    end
  end

  task automatic sweep(input string tag);
    for (int c = 0; c < 16; c++) step(32'h1234_5678, 32'h0F0F_0F0F, 2'b00, 1'b0, c[3:0], tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    checks++;
    if (flags !== 32'h2) begin
      fails++; $display("FAIL R1 reset flags: actual %h expected %h", flags, 32'h2);
    end
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    step(32'h0, 32'h0, 2'b00, 1'b0, 4'd4, "R1 post-reset");
    sweep("R9 R10 reset flags");
    step(32'h1, 32'h1, 2'b00, 1'b1, 4'd0, "R2 add small");
    step(32'hFFFF_FFFF, 32'h1, 2'b00, 1'b1, 4'd2, "R3 R4 R5 add carry zero");
    sweep("R9 R10 after carry-zero");
    step(32'h7FFF_FFFF, 32'h1, 2'b00, 1'b1, 4'd0, "R4 signed overflow add");
    sweep("R9 R10 after overflow");
    step(32'h5, 32'h7, 2'b01, 1'b1, 4'd2, "R3 R5 sub borrow");
    sweep("R9 R10 after borrow");
    step(32'h8000_0000, 32'h1, 2'b01, 1'b1, 4'd12, "R4 sub overflow");
    sweep("R9 R10 after sub overflow");
    step(32'h3, 32'h3, 2'b10, 1'b1, 4'd4, "R6 cmp equal");
    step(32'hFFFF_FFFF, 32'h1, 2'b10, 1'b1, 4'd12, "R6 R11 cmp signed less same cycle");
    step(32'h1, 32'hFFFF_FFFF, 2'b11, 1'b1, 4'd12, "R2 R6 R11 op3 as cmp");
    sweep("R9 R10 after cmp");
    step(32'hDEAD_BEEF, 32'h1234_5678, 2'b01, 1'b0, 4'd5, "R7 no write sub");
    step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b10, 1'b0, 4'd4, "R7 no write cmp");
    step(32'h0, 32'h0, 2'b00, 1'b0, 4'd4, "R7 R8 held");
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      a = 32'h9E37_79B9 * (i + 1);
      b = 32'h85EB_CA6B ^ (a << 3);
      step(a, b, i[1:0], 1'b1, i[3:0], "R3 R4 R5 R11 mixed");
    end
    step(32'h0, 32'h0, 2'b00, 1'b0, 4'd0, "R11 drain");
    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule